// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel bytes into asynchronous serial frames. The frame shape is chosen at run time through a set of configuration inputs:
- a character length of 5 to 8 bits,
- an optional parity bit, even or odd,
- a stop length of 1, 1.5 or 2 bit times,
- a clock factor, so that one bit lasts 1, 16 or 64 periods of the transmit clock.

The transmit clock arrives as a single-cycle enable, `txc_tick`, on the system clock `clk`.

A byte offered with `wr_stb` lands in a one-entry holding register. From there it moves into the shifter as soon as the shifter is free and transmission is enabled. A new frame can therefore follow the previous stop bits without a gap. `tx_rdy` tells the writer that the holding register is free, and `tx_empty` tells it that the shifter is idle. A break control forces the line low for as long as it is held.

The configuration is captured when a frame starts, so it may be changed while a frame is on the line. A frame that has started always runs to its end, even if transmission is disabled part way through.

Top module: `async_frame_tx`

## Requirements
- R1: After reset `txd` is 1 (idle mark), `tx_rdy` is 1 and `tx_empty` is 1.
- R2: A frame has this order: one start bit at 0, then the data bits with bit 0 first, then the parity bit if enabled, then stop bits at 1. The line returns to 1 when idle.
- R3: `cfg_len` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits above the selected length are not sent.
- R4: When `cfg_par_en` is 1, a parity bit follows the data. With `cfg_par_even` set to 1, the data bits plus the parity bit hold an even number of ones; with it set to 0, they hold an odd number.
- R5: `cfg_stop` selects the stop length: 01 gives 1 bit time, 10 gives 1.5, 11 gives 2, and 00 is treated as 1.
- R6: Every bit except a fractional stop lasts F `txc_tick` pulses. `cfg_factor` sets F: 01 gives 1, 10 gives 16, 11 gives 64, and 00 is treated as 1. No state moves on a cycle without a tick.
- R7: At a factor of 1, the 1.5 stop setting produces 2 stop bit times.
- R8: While `send_brk` is 1, `txd` is 0.
- R9: `tx_rdy` is 1 exactly when the holding register is free. A write made while the register is full is ignored, and that byte is never sent.
- R10: `tx_empty` falls when a frame starts, stays 0 until the last stop period ends, and goes back to 1 when no further frame follows.
- R11: While `tx_en` is 0 no frame starts, and a written byte waits in the holding register. A frame already started completes.
- R12: The configuration is sampled when a frame starts. Changes made during the frame do not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txc_tick | input | 1 | Transmit-clock enable, one pulse per transmit-clock period |
| cfg_len | input | 2 | Character length select |
| cfg_par_en | input | 1 | Parity enable |
| cfg_par_even | input | 1 | 1 selects even parity, 0 selects odd |
| cfg_stop | input | 2 | Stop length select |
| cfg_factor | input | 2 | Clock factor select |
| tx_en | input | 1 | Allows new frames to start |
| send_brk | input | 1 | Forces the line to 0 |
| wr_stb | input | 1 | Single-cycle write strobe for `wr_data` |
| wr_data | input | 8 | Byte to transmit |
| txd | output | 1 | Serial line |
| tx_rdy | output | 1 | Holding register free |
| tx_empty | output | 1 | Shifter idle |

## Verification
The assertions assume that every input is synchronous to `clk` and changes only between rising edges. They also assume that `txc_tick` is a level sampled once per edge rather than a clock of its own, and that `send_brk` is never raised in the middle of a frame whose bits are being checked. The bench drives every input one nanosecond after a rising edge and produces the tick from a fixed pattern that leaves some cycles without a tick. It raises break only while the line is idle. A scoreboard predicts every transmit-clock period of each frame and compares it with the line; the predictions cover the length, parity, stop, factor, back-to-back, disable, ignored-write and mid-frame configuration cases.

// File: rtl/async_frame_tx.sv
module async_frame_tx #(
  parameter int CNT_W = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txc_tick,
  input  logic [1:0] cfg_len,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic [1:0] cfg_stop,
  input  logic [1:0] cfg_factor,
  input  logic       tx_en,
  input  logic       send_brk,
  input  logic       wr_stb,
  input  logic [7:0] wr_data,
  output logic       txd,
  output logic       tx_rdy,
  output logic       tx_empty
);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP} ph_t;

  ph_t              ph;
  logic             hold_full;
  logic [7:0]       hold_data;
  logic [7:0]       shf;
  logic [2:0]       idx;
  logic [CNT_W-1:0] cnt;
  logic [2:0]       f_last_idx;
  logic             f_par_en, f_par_bit;
  logic [CNT_W-1:0] f_bit_last, f_stop_last;

  // ticks per bit, and per stop period
  logic [CNT_W-1:0] fac, stop_ticks;
  always_comb begin
    case (cfg_factor)
      2'b10:   fac = CNT_W'(16);
      2'b11:   fac = CNT_W'(64);
      default: fac = CNT_W'(1);
    endcase
    case (cfg_stop)
      2'b10:   stop_ticks = (fac == CNT_W'(1)) ? CNT_W'(2) : fac + (fac >> 1);
      2'b11:   stop_ticks = fac << 1;
      default: stop_ticks = fac;
    endcase
  end

  logic [7:0] data_m;
  assign data_m = hold_data & (8'hFF >> (2'd3 - cfg_len));

  logic [CNT_W-1:0] cur_last;
  logic bit_end, end_stop, load;
  assign cur_last = (ph == S_STOP) ? f_stop_last : f_bit_last;
  assign bit_end  = txc_tick && (cnt == cur_last);
  assign end_stop = (ph == S_STOP) && bit_end;
  assign load     = hold_full && tx_en && ((ph == S_IDLE) || end_stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (load) begin
      hold_full <= 1'b0;
    end else if (wr_stb && !hold_full) begin
      hold_full <= 1'b1;
      hold_data <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph          <= S_IDLE;
      shf         <= '0;
      idx         <= '0;
      cnt         <= '0;
      f_last_idx  <= '0;
      f_par_en    <= 1'b0;
      f_par_bit   <= 1'b0;
      f_bit_last  <= '0;
      f_stop_last <= '0;
    end else if (load) begin
      ph          <= S_START;
      cnt         <= '0;
      idx         <= '0;
      shf         <= data_m;
      f_last_idx  <= {1'b1, cfg_len} - 3'd4 + 3'd4;
      f_par_en    <= cfg_par_en;
      f_par_bit   <= (^data_m) ^ ~cfg_par_even;
      f_bit_last  <= fac - CNT_W'(1);
      f_stop_last <= stop_ticks - CNT_W'(1);
    end else if (txc_tick && ph != S_IDLE) begin
      if (bit_end) begin
        cnt <= '0;
        case (ph)
          S_START: ph <= S_DATA;
          S_DATA: begin
            shf <= shf >> 1;
            if (idx == f_last_idx) ph <= f_par_en ? S_PAR : S_STOP;
            else idx <= idx + 3'd1;
          end
          S_PAR:   ph <= S_STOP;
          default: ph <= S_IDLE;
        endcase
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  always_comb begin
    case (ph)
      S_START: txd = 1'b0;
      S_DATA:  txd = shf[0];
      S_PAR:   txd = f_par_bit;
      default: txd = 1'b1;
    endcase
    if (send_brk) txd = 1'b0;
  end

  assign tx_rdy   = !hold_full;
  assign tx_empty = (ph == S_IDLE);

  a_r8_break_low: assert property (@(posedge clk) disable iff (!rst_n)
    send_brk |-> !txd);
  a_r9_no_overwrite: assert property (@(posedge clk) disable iff (!rst_n)
    hold_full && wr_stb && !load |=> hold_data == $past(hold_data));
  a_r11_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en && tx_empty |=> tx_empty);
  a_r10_start_low: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_empty) && !send_brk |-> !txd);
  a_r2_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
    ph == S_STOP && !send_brk |-> txd);
  a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
    ph != S_IDLE && !txc_tick |=> $stable(ph) && $stable(cnt));

endmodule

// File: tb/sim_async_frame_tx.sv
`timescale 1ns/100ps
module sim_async_frame_tx;
  logic clk = 0, rst_n = 0, txc_tick = 0;
  logic [1:0] cfg_len = 2'b11, cfg_stop = 2'b01, cfg_factor = 2'b01;
  logic cfg_par_en = 0, cfg_par_even = 0, tx_en = 1, send_brk = 0, wr_stb = 0;
  logic [7:0] wr_data = 0;
  logic txd, tx_rdy, tx_empty;

  int checks = 0, errors = 0;
  bit brk_on = 0;
  bit bitq[$];
  int lenq[$];
  string tagq[$];

  always #2.5 clk = ~clk;

  async_frame_tx u0 (.*);

  // transmit-clock: two ticks out of every three cycles
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      txc_tick = (c % 3 != 2);
      c++;
    end
  end

  // monitor: compare the line once per tick against the scoreboard
  initial begin
    int rem = 0, pos = 0;
    bit bad = 0, skip = 0, e;
    string lbl;
    forever begin
      @(negedge clk);
      if (!rst_n || !txc_tick) continue;
      if (skip) begin if (txd) skip = 0; continue; end
      if (rem == 0) begin
        if (txd || brk_on) continue;
        if (lenq.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: unexpected frame, actual start bit 0, expected idle 1");
          skip = 1;
          continue;
        end
        rem = lenq.pop_front(); lbl = tagq.pop_front(); bad = 0; pos = 0;
      end
      e = bitq.pop_front();
      if (txd !== e && !bad) begin
        bad = 1;
        $display("FAIL %s: tick %0d actual %b expected %b", lbl, pos, txd, e);
      end
      pos++; rem--;
      if (rem == 0) begin checks++; if (bad) errors++; end
    end
  end

  task automatic chk(input string r, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", r, act, exp);
    end
  endtask

  task automatic expect_frame(input [7:0] d, input [1:0] len, input pe, ev,
                              input [1:0] stp, fac, input string tag);
    int f, s, n, tot;
    bit p;
    f = (fac == 2'b10) ? 16 : (fac == 2'b11) ? 64 : 1;
    s = (stp == 2'b11) ? 2*f : (stp == 2'b10) ? ((f == 1) ? 2 : f + f/2) : f;
    n = len + 5;
    p = !ev;
    tot = 0;
    for (int i = 0; i < f; i++) begin bitq.push_back(0); tot++; end
    for (int b = 0; b < n; b++) begin
      p ^= d[b];
      for (int i = 0; i < f; i++) begin bitq.push_back(d[b]); tot++; end
    end
    if (pe) for (int i = 0; i < f; i++) begin bitq.push_back(p); tot++; end
    for (int i = 0; i < s; i++) begin bitq.push_back(1); tot++; end
    lenq.push_back(tot);
    tagq.push_back(tag);
  endtask

  task automatic set_cfg(input [1:0] len, input pe, ev, input [1:0] stp, fac);
    @(posedge clk); #1;
    cfg_len = len; cfg_par_en = pe; cfg_par_even = ev; cfg_stop = stp; cfg_factor = fac;
  endtask

  task automatic strobe(input [7:0] d);
    @(posedge clk); #1; wr_stb = 1; wr_data = d;
    @(posedge clk); #1; wr_stb = 0;
  endtask

  task automatic wr(input [7:0] d);
    do @(negedge clk); while (!tx_rdy);
    strobe(d);
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!(tx_rdy && tx_empty));
    repeat (3) @(negedge clk);
  endtask

  task automatic frame(input [7:0] d, input [1:0] len, input pe, ev,
                       input [1:0] stp, fac, input string tag);
    set_cfg(len, pe, ev, stp, fac);
    expect_frame(d, len, pe, ev, stp, fac, tag);
    wr(d);
    wait_done();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk); #1; rst_n = 1;
    @(negedge clk);
    chk("R1 txd idle", txd, 1);
    chk("R1 tx_rdy", tx_rdy, 1);
    chk("R1 tx_empty", tx_empty, 1);

    frame(8'hA5, 2'b11, 0, 0, 2'b01, 2'b01, "R2 8N1 x1");
    frame(8'h3C, 2'b11, 0, 0, 2'b01, 2'b10, "R2 8N1 x16");
    frame(8'hFF, 2'b00, 0, 0, 2'b01, 2'b01, "R3 len5");
    frame(8'hD6, 2'b01, 0, 0, 2'b01, 2'b01, "R3 len6");
    frame(8'hB9, 2'b10, 0, 0, 2'b01, 2'b10, "R3 len7");
    frame(8'h53, 2'b10, 1, 1, 2'b01, 2'b01, "R4 even parity");
    frame(8'h53, 2'b10, 1, 0, 2'b01, 2'b01, "R4 odd parity");
    frame(8'h00, 2'b11, 1, 0, 2'b01, 2'b01, "R4 odd parity zero");
    frame(8'h81, 2'b11, 0, 0, 2'b10, 2'b10, "R5 stop 1.5 x16");
    frame(8'h42, 2'b11, 0, 0, 2'b11, 2'b01, "R5 stop 2 x1");
    frame(8'h42, 2'b11, 0, 0, 2'b00, 2'b01, "R5 stop code 00");
    frame(8'h6E, 2'b11, 1, 1, 2'b10, 2'b11, "R6 x64 stop 1.5");
    frame(8'h91, 2'b11, 0, 0, 2'b01, 2'b00, "R6 factor code 00");
    frame(8'h17, 2'b11, 0, 0, 2'b10, 2'b01, "R7 stop 1.5 at x1");

    // back-to-back, holding register, ignored write
    set_cfg(2'b11, 0, 0, 2'b01, 2'b10);
    expect_frame(8'h11, 2'b11, 0, 0, 2'b01, 2'b10, "R9 first of pair");
    expect_frame(8'hEE, 2'b11, 0, 0, 2'b01, 2'b10, "R9 second of pair");
    wr(8'h11);
    wr(8'hEE);
    @(negedge clk);
    chk("R9 tx_rdy low when full", tx_rdy, 0);
    chk("R10 tx_empty low in frame", tx_empty, 0);
    strobe(8'h77);
    wait_done();
    chk("R10 tx_empty after frames", tx_empty, 1);

    // transmit disabled: byte waits
    set_cfg(2'b11, 0, 0, 2'b01, 2'b01);
    @(posedge clk); #1; tx_en = 0;
    expect_frame(8'hC3, 2'b11, 0, 0, 2'b01, 2'b01, "R11 released frame");
    wr(8'hC3);
    repeat (60) @(negedge clk);
    chk("R11 no start txd", txd, 1);
    chk("R11 no start tx_empty", tx_empty, 1);
    chk("R11 byte held tx_rdy", tx_rdy, 0);
    @(posedge clk); #1; tx_en = 1;
    do @(negedge clk); while (tx_empty);
    @(posedge clk); #1; tx_en = 0;
    wait_done();
    chk("R11 frame finished", tx_empty, 1);
    @(posedge clk); #1; tx_en = 1;

    // break while idle
    @(posedge clk); #1; brk_on = 1; send_brk = 1;
    repeat (5) @(negedge clk);
    chk("R8 break forces 0", txd, 0);
    @(posedge clk); #1; send_brk = 0;
    @(negedge clk);
    chk("R8 line back to 1", txd, 1);
    repeat (3) @(posedge clk); #1; brk_on = 0;

    // configuration change mid-frame
    set_cfg(2'b11, 0, 0, 2'b01, 2'b01);
    expect_frame(8'h5A, 2'b11, 0, 0, 2'b01, 2'b01, "R12 config held");
    wr(8'h5A);
    do @(negedge clk); while (tx_empty);
    set_cfg(2'b00, 1, 1, 2'b11, 2'b10);
    wait_done();
    set_cfg(2'b11, 0, 0, 2'b01, 2'b01);

    repeat (20) @(negedge clk);
    checks++;
    if (lenq.size() != 0) begin
      errors++;
      $display("FAIL R2: frames missing, actual %0d left, expected 0", lenq.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule